// File: doc/BRIEF.md
# Factorial accelerator register block

This block is a small memory-mapped register slice for a device. It holds a fixed identification word, a liveness register that keeps the bitwise complement of whatever software last wrote to it, and a factorial engine. Software writes an operand to the engine's data register. The engine then works out the factorial of that operand over several clock cycles, one 32-bit wrapping multiply per cycle. When it finishes, the result is written back into the same data register and the busy flag in the status word clears.

A completion-interrupt enable bit sits in the status word. When that bit is set, the end of each computation produces a one-cycle request on `irq_set_o`. That request asks an interrupt status register outside this block to set its bit 0. Accesses are single-beat and carry a byte size. Only 4-byte accesses take effect. A read returns its data one cycle after the request.

Top module: `fact_regblk`

## Requirements
- R1: A 4-byte read is answered with `rsp_valid_o` high exactly one cycle after the request. A read of offset 0x00 returns 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the write data. A read of 0x04 returns the stored word. The reset value is 0.
- R3: A 4-byte write to offset 0x08 while idle loads the operand and sets the busy flag (status bit 0). A status read issued in the next cycle sees busy = 1.
- R4: A write to offset 0x08 while busy is set has no effect. The running computation and its result are unchanged.
- R5: When busy clears, offset 0x08 reads the product of 1 through the operand, truncated to 32 bits. Operands 0 and 1 both give 1.
- R6: The status word at offset 0x20 has busy in bit 0 and the completion-interrupt enable in bit 7. All other bits read 0. A write changes only bit 7, and the enable resets to 0.
- R7: At the edge where busy clears, `irq_set_o` goes high for exactly one cycle if the enable is set. It stays low if the enable is clear.
- R8: An access whose byte size is not 4 is ignored: a write changes nothing, and a read returns 0xFFFFFFFF.
- R9: A read of any offset other than 0x00, 0x04, 0x08 and 0x20 returns 0xFFFFFFFF. A write to such an offset changes nothing.
- R10: For operand v, busy stays high for max(v,1) cycles after the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset |
| req_bytes_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_data_o | output | 32 | Read data |
| irq_set_o | output | 1 | One-cycle request to set interrupt status bit 0 |

## Verification
Read data is due on the cycle after the request edge, so the bench samples `rsp_data_o` at the following falling edge. Because of this, back-to-back reads sample consecutive edges. Busy rises at the edge that accepts the operand and falls max(v,1) edges later; `irq_set_o` is high in the cycle after that fall.

The bench polls the status register once per cycle, starting right after the operand write. It checks that the number of reads seeing busy equals max(v,1). It counts interrupt pulses at falling edges and compares that count with the enable bit. The result is read only after the poll sees busy clear.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BYTES_W = 4;
  localparam int unsigned FULL_BYTES = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_INV   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OPER  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h20;

  localparam logic [DATA_W-1:0] IDENT_WORD = 32'h0100_00ED;
  localparam int unsigned BUSY_BIT = 0;
  localparam int unsigned IEN_BIT  = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_IDENT, SEL_INV, SEL_OPER, SEL_STAT
  } rd_sel_e;

  // wrapping product of two words
  function automatic logic [DATA_W-1:0] mul_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] p;
    p = a * b;
    return p[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] stat_word(input logic busy,
                                                  input logic ien);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BUSY_BIT] = busy;
    w[IEN_BIT] = ien;
    return w;
  endfunction
endpackage

// File: rtl/fact_decode.sv
module fact_decode
  import fact_pkg::*;
(
  input  logic               valid_i,
  input  logic               write_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTES_W-1:0] bytes_i,
  output logic               wr_inv_o,
  output logic               wr_oper_o,
  output logic               wr_stat_o,
  output logic               rd_o,
  output rd_sel_e            rd_sel_o
);
  logic size_ok;
  logic wr_ok;

  always_comb begin
    size_ok = (bytes_i == BYTES_W'(FULL_BYTES));
    wr_ok = valid_i && write_i && size_ok;
    wr_inv_o = wr_ok && (addr_i == OFS_INV);
    wr_oper_o = wr_ok && (addr_i == OFS_OPER);
    wr_stat_o = wr_ok && (addr_i == OFS_STAT);
    rd_o = valid_i && !write_i;
    rd_sel_o = SEL_NONE;
    if (size_ok) begin
      unique case (addr_i)
        OFS_IDENT: rd_sel_o = SEL_IDENT;
        OFS_INV:   rd_sel_o = SEL_INV;
        OFS_OPER:  rd_sel_o = SEL_OPER;
        OFS_STAT:  rd_sel_o = SEL_STAT;
        default:   rd_sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fact_ctrl_regs.sv
module fact_ctrl_regs
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_inv_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] inv_q_o,
  output logic              ien_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q_o <= '0;
      ien_q_o <= 1'b0;
    end else begin
      if (wr_inv_i) inv_q_o <= ~wdata_i;
      if (wr_stat_i) ien_q_o <= wdata_i[IEN_BIT];
    end
  end
endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic              load_acc_o,
  output logic              fin_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] value_o
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] val_q;
  logic              busy_q;

  assign load_acc_o = load_req_i && !busy_q;
  assign fin_o = busy_q && (cnt_q <= DATA_W'(1));
  assign busy_o = busy_q;
  assign value_o = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      val_q <= '0;
      busy_q <= 1'b0;
    end else if (load_acc_o) begin
      val_q <= load_val_i;
      cnt_q <= load_val_i;
      acc_q <= DATA_W'(1);
      busy_q <= 1'b1;
    end else if (fin_o) begin
      val_q <= acc_q;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      acc_q <= mul_wrap(acc_q, cnt_q);
      cnt_q <= cnt_q - DATA_W'(1);
    end
  end
endmodule

// File: rtl/fact_regblk.sv
module fact_regblk
  import fact_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [BYTES_W-1:0] req_bytes_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic               irq_set_o
);
  logic wr_inv, wr_oper, wr_stat, rd_req;
  rd_sel_e rd_sel;
  logic [DATA_W-1:0] inv_q, eng_val;
  logic ien_q, eng_busy, eng_fin, eng_load_acc;
  logic [DATA_W-1:0] rd_mux;

  fact_decode u_dec (
    .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i),
    .bytes_i(req_bytes_i), .wr_inv_o(wr_inv), .wr_oper_o(wr_oper),
    .wr_stat_o(wr_stat), .rd_o(rd_req), .rd_sel_o(rd_sel)
  );

  fact_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_inv_i(wr_inv), .wr_stat_i(wr_stat),
    .wdata_i(req_wdata_i), .inv_q_o(inv_q), .ien_q_o(ien_q)
  );

  fact_engine u_eng (
    .clk(clk), .rst_n(rst_n), .load_req_i(wr_oper), .load_val_i(req_wdata_i),
    .load_acc_o(eng_load_acc), .fin_o(eng_fin), .busy_o(eng_busy),
    .value_o(eng_val)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_IDENT: rd_mux = IDENT_WORD;
      SEL_INV:   rd_mux = inv_q;
      SEL_OPER:  rd_mux = eng_val;
      SEL_STAT:  rd_mux = stat_word(eng_busy, ien_q);
      default:   rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o <= '0;
      irq_set_o <= 1'b0;
    end else begin
      rsp_valid_o <= rd_req;
      if (rd_req) rsp_data_o <= rd_mux;
      irq_set_o <= eng_fin && ien_q;
    end
  end
endmodule

// File: rtl/fact_regblk_chk.sv
module fact_regblk_chk
  import fact_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic [BYTES_W-1:0] req_bytes_i,
  input logic               rsp_valid_o,
  input logic [DATA_W-1:0]  rsp_data_o,
  input logic               irq_set_o,
  input logic               eng_busy,
  input logic               eng_fin,
  input logic               eng_load_acc,
  input logic [DATA_W-1:0]  eng_val
);
  assert_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && $past(req_addr_i) == OFS_IDENT &&
    $past(req_bytes_i) == BYTES_W'(FULL_BYTES) |-> rsp_data_o == IDENT_WORD);

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load_acc |=> eng_busy);

  assert_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && !eng_fin |=> $stable(eng_val));

  assert_irq_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |-> $fell(eng_busy));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |=> !irq_set_o);

  assert_badsize_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && $past(req_bytes_i) != BYTES_W'(FULL_BYTES) |-> rsp_data_o == '1);

  assert_rsp_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !req_write_i |=> rsp_valid_o);
endmodule

bind fact_regblk fact_regblk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i),
  .req_bytes_i(req_bytes_i), .rsp_valid_o(rsp_valid_o),
  .rsp_data_o(rsp_data_o), .irq_set_o(irq_set_o), .eng_busy(eng_busy),
  .eng_fin(eng_fin), .eng_load_acc(eng_load_acc), .eng_val(eng_val)
);

// File: tb/fact_regblk_tb.sv
module fact_regblk_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [3:0] req_bytes = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic irq;
  int checks = 0, errors = 0, irq_cnt = 0;

  always #5 clk = ~clk;

  fact_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_bytes_i(req_bytes), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .irq_set_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  function automatic logic [31:0] exp_fact(input int unsigned v);
    logic [31:0] p = 32'd1;
    for (int unsigned i = 2; i <= v; i++) p = p * i;
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_bytes = b;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] b = 4);
    req_valid = 1; req_write = 0; req_addr = a; req_bytes = b;
    @(negedge clk);
    req_valid = 0;
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R1 actual=rsp_valid 0 expected=1");
    end
    d = rsp_data;
  endtask

  // write operand, count busy status reads, check result and irq
  task automatic run_fact(input int unsigned v, input logic ien);
    logic [31:0] d;
    int busy_reads = 0;
    int irq0;
    irq0 = irq_cnt;
    wr(8'h08, v);
    rd(8'h20, d);
    chk("R3", {31'd0, d[0]}, 32'd1);
    busy_reads = 1;
    while (d[0] && busy_reads < 100) begin
      rd(8'h20, d);
      if (d[0]) busy_reads++;
    end
    chk("R10", busy_reads, (v == 0) ? 1 : v);
    rd(8'h08, d);
    chk("R5", d, exp_fact(v));
    chk("R7", irq_cnt - irq0, {31'd0, ien});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(8'h20, d); chk("R6 reset", d, 32'h0);
    rd(8'h04, d); chk("R2 reset", d, 32'h0);
    rd(8'h00, d); chk("R1", d, 32'h0100_00ED);
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, d); chk("R2", d, 32'hEDCB_A987);

    // R8: wrong size accesses
    wr(8'h04, 32'h0, 4'd2);
    rd(8'h04, d); chk("R8 write", d, 32'hEDCB_A987);
    rd(8'h04, d, 4'd1); chk("R8 read", d, 32'hFFFF_FFFF);
    wr(8'h08, 32'd5, 4'd8);
    rd(8'h20, d); chk("R8 oper", d, 32'h0);

    // R9: unmapped
    rd(8'h24, d); chk("R9 read", d, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R9 stat", d, 32'h0);
    rd(8'h04, d); chk("R9 inv", d, 32'hEDCB_A987);

    // R6: only bit 7 writable
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R6", d, 32'h80);

    // corners: 0, 1, wrap at 13 and 20
    run_fact(0, 1'b1);
    run_fact(1, 1'b1);
    run_fact(13, 1'b1);
    wr(8'h20, 32'h0);
    run_fact(20, 1'b0);

    // R4: write during busy ignored
    wr(8'h08, 32'd10);
    wr(8'h08, 32'd3);
    rd(8'h20, d);
    while (d[0]) rd(8'h20, d);
    rd(8'h08, d); chk("R4", d, exp_fact(10));

    // random mix
    for (int i = 0; i < 24; i++) begin
      int unsigned v;
      logic en;
      v = $urandom % 18;
      en = 1'($urandom % 2);
      wr(8'h20, ($urandom & 32'hFFFF_FF7F) | {24'd0, en, 7'd0});
      rd(8'h20, d); chk("R6 rand", d, {24'd0, en, 7'd0});
      run_fact(v, en);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule